// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a processor through a single strobe line. The processor must change the level of the strobe at a steady rate. Each change, rising or falling, counts as a service. The block measures the number of clock cycles between consecutive services. A service that comes too early is a fast fault. A gap that runs too long is a slow fault. Either fault pulls an active-low reset output down for a fixed number of cycles, and a two-bit cause output records which fault occurred.

The long limit `SLOW_TICKS` is a parameter given in clock cycles. The short limit is derived from it by a ratio, and a two-bit select input picks that ratio. One code of the select turns supervision off. A separate active-low inhibit input also turns supervision off. The strobe is resynchronised inside the block, so it may come from any clock domain.

Top module: `wdw_window_sup`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rst_out_n_o` is 1 and `fault_cause_o` is 2'b00.
- R2: Rising and falling changes of `strobe_i` both count as services. The spacing between two services is the number of clock cycles between the two changes.
- R3: The short limit F depends on `win_sel_i`: 2'b00 gives SLOW_TICKS>>3, 2'b10 gives SLOW_TICKS>>4 and 2'b11 gives SLOW_TICKS>>6. A spacing of exactly F is accepted.
- R4: When supervision is armed, a service spaced fewer than F cycles after the previous service is a fast fault. `rst_out_n_o` goes low at the third rising clock edge after the offending strobe change.
- R5: A spacing of exactly SLOW_TICKS cycles is accepted. If no service is taken at the SLOW_TICKS-th rising edge after the previous reference, a slow fault pulls `rst_out_n_o` low at that edge.
- R6: Once asserted, `rst_out_n_o` stays low for exactly RST_TICKS clock cycles.
- R7: While `rst_out_n_o` is low, strobe changes are ignored and the interval counter is held at zero. The edge at which `rst_out_n_o` returns high is the new timing reference.
- R8: The first service after reset release, or after supervision is re-enabled, is never a fast fault. Later services are checked against F.
- R9: When `win_sel_i` is 2'b01, no fault is raised, whatever the strobe does.
- R10: When `wd_inhibit_n_i` is 0, no fault is raised, whatever the strobe does.
- R11: `fault_cause_o` is loaded when the reset asserts. Bit 0 means fast fault and bit 1 means slow fault. At most one bit is set.
- R12: `fault_cause_o` keeps its value through the reset pulse. It clears to 2'b00 at the third rising edge after the first accepted service that follows release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| strobe_i | input | 1 | Service strobe from the processor, asynchronous |
| win_sel_i | input | 2 | Ratio select: 00 /8, 10 /16, 11 /64, 01 off |
| wd_inhibit_n_i | input | 1 | Low turns supervision off |
| rst_out_n_o | output | 1 | Active-low supervisor reset, registered |
| fault_cause_o | output | 2 | Bit 0 fast fault, bit 1 slow fault, registered |

## Verification
The assertions for the two off conditions compare the select and inhibit inputs one cycle back with the reset output now. They therefore assume that these controls change only between clock edges and are settled for a full cycle. The bench drives them on falling edges only. The synchroniser starts from zero, so the strobe must be low when `rst` is released; otherwise a spurious first service appears. The bench holds it low during reset. Strobe changes are made on falling edges. This keeps each measured spacing equal to the number of clock cycles the bench waited, so the bench can compute every fault edge from F, SLOW_TICKS and RST_TICKS.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  // Window ratio select codes; code 01 switches supervision off
  typedef enum logic [1:0] {
    SEL_DIV8  = 2'b00,
    SEL_OFF   = 2'b01,
    SEL_DIV16 = 2'b10,
    SEL_DIV64 = 2'b11
  } win_sel_e;

  // Bit positions inside the fault cause output
  localparam int CAUSE_FAST = 0;
  localparam int CAUSE_SLOW = 1;

  // Right shift that turns the slow window into the fast window
  function automatic int win_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3;
      2'b10:   return 4;
      2'b11:   return 6;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wdw_edge_sync.sv
module wdw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);

  logic [STAGES-1:0] chain;
  logic              hist;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist <= 1'b0;
    else     hist <= chain[STAGES-1];
  end

  // Either polarity of change is a service event
  assign edge_o = chain[STAGES-1] ^ hist;

endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer
  import wdw_pkg::*;
#(
  parameter int SLOW_TICKS = 1024,
  parameter int CNT_W      = $clog2(SLOW_TICKS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       svc_edge,
  input  logic [1:0] win_sel,
  output logic       fast_hit,
  output logic       slow_hit,
  output logic       svc_ok
);

  localparam int LIM_DIV8  = SLOW_TICKS >> win_shift(SEL_DIV8);
  localparam int LIM_DIV16 = SLOW_TICKS >> win_shift(SEL_DIV16);
  localparam int LIM_DIV64 = SLOW_TICKS >> win_shift(SEL_DIV64);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  int               fast_lim;

  always_comb begin
    case (win_sel)
      SEL_DIV8:  fast_lim = LIM_DIV8;
      SEL_DIV16: fast_lim = LIM_DIV16;
      SEL_DIV64: fast_lim = LIM_DIV64;
      default:   fast_lim = 0;
    endcase
  end

  // cnt holds (cycles since last reference - 1) at a service edge
  assign fast_hit = active && svc_edge && armed && ((int'(cnt) + 1) < fast_lim);
  assign slow_hit = active && !svc_edge && (cnt == SLOW_LAST);
  assign svc_ok   = active && svc_edge && !fast_hit;

  always_ff @(posedge clk) begin
    if (rst || !active)          cnt <= '0;
    else if (svc_edge || slow_hit) cnt <= '0;
    else                          cnt <= cnt + CNT_W'(1);
  end

  // Fast check only from the second service after a fresh start
  always_ff @(posedge clk) begin
    if (rst || !active) armed <= 1'b0;
    else if (svc_edge)  armed <= 1'b1;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < SLOW_TICKS);

  assert_cleared_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0));

endmodule

// File: rtl/wdw_reset_pulse.sv
module wdw_reset_pulse
  import wdw_pkg::*;
#(
  parameter int RST_TICKS = 64,
  parameter int TW        = $clog2(RST_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_hit,
  input  logic       slow_hit,
  input  logic       svc_ok,
  output logic       rst_n_o,
  output logic [1:0] cause_o
);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b1;
      tmr     <= '0;
      cause_o <= '0;
    end else if (!rst_n_o) begin
      if (tmr == TW'(RST_TICKS - 1)) begin
        rst_n_o <= 1'b1;
        tmr     <= '0;
      end else begin
        tmr <= tmr + TW'(1);
      end
    end else if (fast_hit || slow_hit) begin
      rst_n_o             <= 1'b0;
      tmr                 <= '0;
      cause_o[CAUSE_FAST] <= fast_hit;
      cause_o[CAUSE_SLOW] <= slow_hit;
    end else if (svc_ok) begin
      cause_o <= '0;
    end
  end

  // Independent measure of the low phase for the pulse-length check
  logic [TW:0] low_run;
  always_ff @(posedge clk) begin
    if (rst)          low_run <= '0;
    else if (rst_n_o) low_run <= '0;
    else              low_run <= low_run + (TW+1)'(1);
  end

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (low_run == (TW+1)'(RST_TICKS)));

  assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_o));

  assert_cause_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> $onehot(cause_o));

endmodule

// File: rtl/wdw_window_sup.sv
module wdw_window_sup
  import wdw_pkg::*;
#(
  parameter int SLOW_TICKS  = 1024,
  parameter int RST_TICKS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  input  logic [1:0] win_sel_i,
  input  logic       wd_inhibit_n_i,
  output logic       rst_out_n_o,
  output logic [1:0] fault_cause_o
);

  logic svc_edge;
  logic wd_en;
  logic active;
  logic fast_hit;
  logic slow_hit;
  logic svc_ok;

  assign wd_en  = wd_inhibit_n_i && (win_sel_i != SEL_OFF);
  assign active = wd_en && rst_out_n_o;

  wdw_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (strobe_i),
    .edge_o (svc_edge)
  );

  wdw_window_timer #(
    .SLOW_TICKS (SLOW_TICKS)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .svc_edge (svc_edge),
    .win_sel  (win_sel_i),
    .fast_hit (fast_hit),
    .slow_hit (slow_hit),
    .svc_ok   (svc_ok)
  );

  wdw_reset_pulse #(
    .RST_TICKS (RST_TICKS)
  ) i_pulse (
    .clk      (clk),
    .rst      (rst),
    .fast_hit (fast_hit),
    .slow_hit (slow_hit),
    .svc_ok   (svc_ok),
    .rst_n_o  (rst_out_n_o),
    .cause_o  (fault_cause_o)
  );

  assert_fast_reset_R4: assert property (@(posedge clk) disable iff (rst)
    fast_hit |=> (!rst_out_n_o && fault_cause_o[CAUSE_FAST]));

  assert_sel_off_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(win_sel_i) == SEL_OFF) && $past(rst_out_n_o)) |-> rst_out_n_o);

  assert_inhibit_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(wd_inhibit_n_i) && $past(rst_out_n_o)) |-> rst_out_n_o);

endmodule

// File: tb/test_wdw_window_sup.sv
module test_wdw_window_sup;

  localparam int SLOW = 128;
  localparam int RSTT = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       strobe;
  logic [1:0] win_sel;
  logic       inh_n;
  logic       rst_out_n;
  logic [1:0] cause;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdw_window_sup #(
    .SLOW_TICKS  (SLOW),
    .RST_TICKS   (RSTT),
    .SYNC_STAGES (2)
  ) i_wdw_window_sup (
    .clk            (clk),
    .rst            (rst),
    .strobe_i       (strobe),
    .win_sel_i      (win_sel),
    .wd_inhibit_n_i (inh_n),
    .rst_out_n_o    (rst_out_n),
    .fault_cause_o  (cause)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Toggle the strobe d cycles after the previous toggle; see the reset still high first
  task automatic service(input int d, input string req);
    repeat (d) @(negedge clk);
    if (d >= 3) check(req, int'(rst_out_n), 1);
    strobe = ~strobe;
  endtask

  // Called on a negedge already showing the reset low, start = lows seen so far
  task automatic wait_release(input int start, output int len);
    len = start;
    @(negedge clk);
    while (!rst_out_n && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic round(input logic [1:0] code, input int shift);
    int f;
    int len;
    f = SLOW >> shift;
    // R9: code 01 turns supervision off
    win_sel = 2'b01;
    for (int i = 0; i < 4; i++) service(1, "R9");
    idle(2 * SLOW);
    check("R9", int'(rst_out_n), 1);
    win_sel = code;
    // R8: first service after enable is not fast checked
    service(1, "R8");
    service(f, "R3");
    service(f + 1, "R2");
    service((f + SLOW) / 2, "R2");
    service(SLOW - 1, "R5");
    service(SLOW, "R5");
    service(f, "R3");
    // R4: one cycle short of the fast window
    service(f - 1, "R4");
    @(negedge clk); check("R4", int'(rst_out_n), 1);
    @(negedge clk); check("R4", int'(rst_out_n), 1);
    @(negedge clk); check("R4", int'(rst_out_n), 0);
    check("R11", int'(cause), 1);
    // R7: strobe changes during the pulse are ignored
    @(negedge clk); strobe = ~strobe;
    @(negedge clk); strobe = ~strobe;
    wait_release(3, len);
    check("R6", len, RSTT);
    check("R12", int'(cause), 1);
    // R7: timing restarts at release, slow fault exactly SLOW later
    idle(SLOW - 1);
    check("R7", int'(rst_out_n), 1);
    idle(1);
    check("R5", int'(rst_out_n), 0);
    check("R11", int'(cause), 2);
    wait_release(1, len);
    check("R6", len, RSTT);
    // R12: cause clears on the first accepted service
    service(1, "R12");
    @(negedge clk); check("R12", int'(cause), 2);
    @(negedge clk); check("R12", int'(cause), 2);
    @(negedge clk); check("R12", int'(cause), 0);
    check("R8", int'(rst_out_n), 1);
  endtask

  initial begin
    rst     = 1'b1;
    strobe  = 1'b0;
    win_sel = 2'b00;
    inh_n   = 1'b1;
    idle(3);
    check("R1", int'(rst_out_n), 1);
    check("R1", int'(cause), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(rst_out_n), 1);
    check("R1", int'(cause), 0);

    round(2'b00, 3);
    round(2'b10, 4);
    round(2'b11, 6);

    // R10: inhibit low keeps the reset high despite fast and missing services
    win_sel = 2'b00;
    inh_n   = 1'b0;
    for (int i = 0; i < 6; i++) service(1, "R10");
    idle(3 * SLOW);
    check("R10", int'(rst_out_n), 1);
    inh_n = 1'b1;
    service(1, "R10");
    service(SLOW >> 3, "R10");
    idle(3);
    check("R10", int'(rst_out_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 200000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule